// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is an up counter built from identical 4-bit stages, all clocked on the rising edge of one clock and chained so that the whole chain behaves as one wide binary counter. Each stage takes an active-low synchronous clear, an active-low synchronous parallel load with its own slice of a data word, and two active-high count enables. One enable is shared by every stage. The other, the carry enable, passes from stage to stage through a combinational terminal-count flag. A stage's flag is high only when its carry enable is high and its own count is all ones, so the carry ripples forward without adding a clock of delay.

The stage modes have a fixed priority: clear wins over load, load wins over counting, and counting needs both enables high. With any enable low the count holds. The top level also provides a modulo mode. When it is enabled, a compare of the count against a programmed final value is fed back into the clear, so the count returns to zero on the edge after it reaches that value. An asynchronous active-low reset, released through a two-flop synchroniser, puts the count at zero.

Top module: `cascade_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `carry_out` is 0. After `rst_n` rises between edges, the count stays 0 through the next two rising edges and can change from the third edge on.
- R2: When `clr_n` is low at a rising edge, `count` becomes 0 on that edge, regardless of `ld_n`, `ld_data`, `cnt_en` and `cin`.
- R3: When `clr_n` is high and `ld_n` is low at a rising edge, `count` takes the value of `ld_data` (bit i of the data goes to bit i of the count), regardless of `cnt_en` and `cin`.
- R4: When `clr_n` and `ld_n` are both high and `cnt_en` and `cin` are both high at a rising edge, `count` increases by one.
- R5: When `clr_n` and `ld_n` are both high and `cnt_en` or `cin` is low, `count` keeps its value. Each of the two enables holds the count on its own.
- R6: Incrementing from all ones wraps `count` to 0.
- R7: `carry_out` is high exactly when `cin` is high and every bit of `count` is 1. It follows `cin` without waiting for a clock edge.
- R8: Carries cross every 4-bit stage boundary, so a chain of STAGES stages counts through all 2^(4*STAGES) values in plain binary order.
- R9: When `lim_en` is high and `count` equals `lim_val` at a rising edge, `count` becomes 0 on that edge. The same holds when the enables are low and when `ld_n` is low, because the compare acts as a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_n | input | 1 | Synchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| ld_data | input | 4*STAGES | Value loaded into the count |
| cnt_en | input | 1 | Shared count enable, sent to every stage |
| cin | input | 1 | Carry enable into the first stage; tied high for a stand-alone counter |
| lim_en | input | 1 | Turns on modulo mode (clear when the count matches) |
| lim_val | input | 4*STAGES | Final count value in modulo mode |
| count | output | 4*STAGES | Current count |
| carry_out | output | 1 | Terminal-count flag of the last stage, for chaining further counters |

## Verification
On every cycle the assertions check the mode priority inside each stage (clear, then load, then increment, then hold), the one-step increment of the whole chain, the modulo clear, and the relation between `carry_out`, `cin` and an all-ones count. Some behaviour shows only in the bench's scenarios: the full binary order across stage boundaries, the wrap after the last value, the two-edge delay of the reset release, and the immediate, clockless drop of `carry_out` when `cin` falls. The bench sweeps every value of the default three-stage chain and runs modulo mode for a set of final values. Its expected results come from an arithmetic model of the requirements.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_INC  = 2'd1,
    MODE_LOAD = 2'd2,
    MODE_CLR  = 2'd3
  } cnt_mode_e;

  // Fixed priority: clear, then load, then count (both enables), else hold.
  function automatic cnt_mode_e pick_mode(input logic clr_n,
                                          input logic ld_n,
                                          input logic pe,
                                          input logic te);
    cnt_mode_e m;
    if (!clr_n)        m = MODE_CLR;
    else if (!ld_n)    m = MODE_LOAD;
    else if (pe && te) m = MODE_INC;
    else               m = MODE_HOLD;
    return m;
  endfunction

endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [DEPTH-1:0] sync_r;
  logic [DEPTH-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_r[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= '0;
    else        sync_r <= sync_nxt;
  end

  assign rst_q_n = sync_r[DEPTH-1];

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  input  logic         pe,
  input  logic         te,
  output logic [W-1:0] q,
  output logic         tc
);

  localparam logic [W-1:0] ONE = W'(1);

  cnt_mode_e    mode;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         q_upd;
  logic         at_top;

  always_comb begin
    mode  = pick_mode(clr_n, ld_n, pe, te);
    q_upd = (mode != MODE_HOLD);
    unique case (mode)
      MODE_CLR:  q_nxt = '0;
      MODE_LOAD: q_nxt = d;
      MODE_INC:  q_nxt = q_r + ONE;
      default:   q_nxt = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= '0;
    else if (q_upd) q_r <= q_nxt;
  end

  // Terminal count is gated by the carry enable with no register in the path.
  always_comb begin
    at_top = &q_r;
    tc     = te & at_top;
  end

  assign q = q_r;

  AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0)); // R2
  AST_LOAD_OVER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> (q == $past(d))); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && pe && te) |=> (q == W'($past(q) + ONE))); // R4
  AST_HOLD_LOW_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !(pe && te)) |=> $stable(q)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && pe && te && (&q)) |=> (q == '0)); // R6

endmodule

// File: rtl/cnt_limit.sv
module cnt_limit #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             lim_en,
  input  logic [WIDTH-1:0] lim_val,
  input  logic             clr_n,
  output logic             clr_eff_n
);

  logic hit;

  always_comb begin
    hit       = lim_en && (cur == lim_val);
    clr_eff_n = clr_n && !hit;
  end

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGES = 3,
  parameter int SW     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_n,
  input  logic                   ld_n,
  input  logic [STAGES*SW-1:0]   ld_data,
  input  logic                   cnt_en,
  input  logic                   cin,
  input  logic                   lim_en,
  input  logic [STAGES*SW-1:0]   lim_val,
  output logic [STAGES*SW-1:0]   count,
  output logic                   carry_out
);

  localparam int WIDTH = STAGES * SW;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic              rst_q_n;
  logic              clr_eff_n;
  logic [STAGES:0]   te_chain;
  logic [WIDTH-1:0]  cnt_w;

  cnt_rst_sync #(.DEPTH(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cnt_limit #(.WIDTH(WIDTH)) u_lim (
    .cur       (cnt_w),
    .lim_en    (lim_en),
    .lim_val   (lim_val),
    .clr_n     (clr_n),
    .clr_eff_n (clr_eff_n)
  );

  assign te_chain[0] = cin;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    cnt_stage #(.W(SW)) u_stage (
      .clk   (clk),
      .rst_n (rst_q_n),
      .clr_n (clr_eff_n),
      .ld_n  (ld_n),
      .d     (ld_data[i*SW +: SW]),
      .pe    (cnt_en),
      .te    (te_chain[i]),
      .q     (cnt_w[i*SW +: SW]),
      .tc    (te_chain[i+1])
    );
  end

  assign count     = cnt_w;
  assign carry_out = te_chain[STAGES];

  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_eff_n && ld_n && cnt_en && cin) |=> (count == WIDTH'($past(count) + ONE))); // R8
  AST_LIMIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lim_en && (count == lim_val)) |=> (count == '0)); // R9
  AST_CARRY_HIGH: assert property (@(posedge clk) disable iff (!rst_q_n)
    carry_out |-> (cin && (&count))); // R7
  AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cin && (&count)) |-> carry_out); // R7
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_q_n |-> (count == '0)); // R1

endmodule

// File: tb/cascade_counter_test.sv
module cascade_counter_test;

  localparam int STAGES = 3;
  localparam int SW     = 4;
  localparam int W      = STAGES * SW;
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr_n;
  logic         ld_n;
  logic [W-1:0] ld_data;
  logic         cnt_en;
  logic         cin;
  logic         lim_en;
  logic [W-1:0] lim_val;
  logic [W-1:0] count;
  logic         carry_out;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] exp_cnt;

  cascade_counter #(.STAGES(STAGES), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .ld_data(ld_data),
    .cnt_en(cnt_en), .cin(cin), .lim_en(lim_en), .lim_val(lim_val),
    .count(count), .carry_out(carry_out)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] cur);
    if (!clr_n || (lim_en && cur == lim_val)) return '0;
    if (!ld_n)                                return ld_data;
    if (cnt_en && cin)                        return cur + W'(1);
    return cur;
  endfunction

  task automatic tick(input string req);
    @(posedge clk);
    exp_cnt = model(exp_cnt);
    @(negedge clk);
    check(req, count, exp_cnt);
    check({req, " carry"}, W'(carry_out), W'(cin && (exp_cnt == ALL1)));
  endtask

  task automatic do_load(input logic [W-1:0] v);
    ld_n = 1'b0; ld_data = v;
    tick("R3 load");
    ld_n = 1'b1;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: req=all actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] lvs [0:6];
    lvs[0] = 12'd0; lvs[1] = 12'd1; lvs[2] = 12'd5; lvs[3] = 12'd15;
    lvs[4] = 12'd16; lvs[5] = 12'd255; lvs[6] = 12'd4095;

    rst_n = 1'b0; clr_n = 1'b1; ld_n = 1'b1; ld_data = '0;
    cnt_en = 1'b1; cin = 1'b1; lim_en = 1'b0; lim_val = '0;
    exp_cnt = '0;

    // R1: reset holds zero even with enables high
    repeat (3) @(negedge clk);
    check("R1 reset count", count, '0);
    check("R1 reset carry", W'(carry_out), '0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 release edge1", count, '0);
    @(posedge clk); @(negedge clk);
    check("R1 release edge2", count, '0);
    @(posedge clk); @(negedge clk);
    check("R1 release edge3", count, 12'd1);
    exp_cnt = 12'd1;

    // R4 R6 R7 R8: full sweep through every value and the wrap
    for (int i = 0; i < (1 << W) + 2; i++) tick("R8 sweep");

    // R3: load with both enables low, then with both high
    cnt_en = 1'b0; cin = 1'b0;
    do_load(12'hA5F);
    cnt_en = 1'b1; cin = 1'b1;
    do_load(12'h3C1);

    // R2: clear beats load and enables
    ld_n = 1'b0; ld_data = 12'h777; clr_n = 1'b0;
    tick("R2 clear over load");
    ld_n = 1'b1; clr_n = 1'b1;
    do_load(12'h123);
    clr_n = 1'b0; tick("R2 clear while counting"); clr_n = 1'b1;

    // R5: each enable low on its own
    do_load(12'h456);
    cnt_en = 1'b0;
    repeat (3) tick("R5 hold shared enable low");
    cnt_en = 1'b1; cin = 1'b0;
    repeat (3) tick("R5 hold carry enable low");
    cin = 1'b1;
    tick("R4 resume");

    // R7: carry follows cin with no clock
    cnt_en = 1'b0;
    do_load(ALL1);
    check("R7 carry high at all ones", W'(carry_out), W'(1));
    cin = 1'b0; #1;
    check("R7 carry drops with cin", W'(carry_out), '0);
    cin = 1'b1; #1;
    check("R7 carry returns with cin", W'(carry_out), W'(1));
    cnt_en = 1'b1;
    tick("R6 wrap after all ones");

    // R8: stage boundaries
    do_load(12'h0FE);
    repeat (4) tick("R8 boundary 0FF");
    do_load(12'hEFD);
    repeat (4) tick("R8 boundary EFF");

    // R9: modulo mode over several final values
    lim_en = 1'b1;
    for (int k = 0; k < 7; k++) begin
      lim_val = lvs[k];
      clr_n = 1'b0; tick("R9 start"); clr_n = 1'b1;
      for (int j = 0; j < 2 * (int'(lvs[k]) + 1) + 1; j++) tick("R9 modulo");
    end
    lim_val = 12'd9;
    cnt_en = 1'b0;
    do_load(12'd9);
    check("R9 at final value", count, 12'd9);
    tick("R9 clear with enables low");
    check("R9 zero with enables low", count, '0);
    cnt_en = 1'b1;
    do_load(12'd8);
    tick("R9 reach final");
    ld_n = 1'b0; ld_data = 12'd5;
    tick("R9 clear beats load");
    check("R9 zero over load", count, '0);
    ld_n = 1'b1; lim_en = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule